// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block sits between a set of interrupt request lines and a processor sequencer. Seven sources feed it. A power-down source cannot be masked. Three external lines are set to edge or level sensitivity one by one. One external line is always edge-sensitive, and two lines are always level-sensitive. Each cycle the block picks the highest-priority source that is pending and enabled. It presents that source's index on `irqVec` with the request level `irqReq`. The sequencer accepts it by pulsing `irqAck` and later ends the service routine with `irqDone`.

Software reaches the block through one write port with a 2-bit register select:
- The mask register.
- The control register, which holds the edge/level selects and the nesting enable.
- A write-only register that sets or clears the edge latches.

Separate enable and disable pulses gate all servicing globally. A write to the mask register holds off every request for the one cycle that follows it. The status stack and the sequencer are not part of this block.

Top module: `irq_ctl_top`

## Requirements
- R1: Source index i is the priority order, and index 0 is the highest. Sources are mapped as follows: index 0 is `pwrDownReq`, indices 1..3 are `cfgLine[0..2]`, index 4 is `edgeLine`, and indices 5..6 are `lvlLine[0..1]`. The mask register holds bit i for source i, with 1 meaning enabled. `irqReq` is high when a pending source is selectable, and `irqVec` is the lowest such index.
- R2: Source 0 (power-down) is selectable whatever its mask bit holds.
- R3: In the clock cycle right after a write with `wrSel`=0 (the mask register), `irqReq` is low. Requests show again one cycle later.
- R4: A write with `wrSel`=1 loads the control register. Bits 2..0 select edge mode (1) or level mode (0) for `cfgLine[2..0]`. In edge mode a rising edge sets a latch, and that latch stays pending after the line falls. In level mode the source is pending only while its line is high.
- R5: `edgeLine` is always latched on a rising edge. `lvlLine` sources are never latched and follow their input lines.
- R6: A write with `wrSel`=2 sets the latch of source i through data bit i (0..6) and clears it through data bit 7+i. Set wins over clear. Bits for sources that currently have no latch (level sources) have no effect. A write with `wrSel`=3 is ignored.
- R7: Servicing is enabled out of reset. A pulse on `intDisable` blocks every request, power-down included, until a pulse on `intEnable`. If both pulse in the same cycle, disable wins. Latches keep collecting while servicing is disabled.
- R8: Control bit 3 enables nesting. With nesting on, only sources with a lower index than every source in service may be selected. With nesting off, nothing is selected while any source is in service.
- R9: `irqAck` while `irqReq` is high marks `irqVec` as in service and clears its latch. `irqDone` retires the highest-priority source in service.
- R10: After reset the mask and control registers are zero, no latch is pending and `irqReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrDownReq | input | 1 | Power-down request (nonmaskable, edge) |
| cfgLine | input | 3 | External lines with selectable sensitivity |
| edgeLine | input | 1 | External line, always edge-sensitive |
| lvlLine | input | 2 | External lines, always level-sensitive |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | 0 mask, 1 control, 2 set/clear, 3 unused |
| wrData | input | 14 | Write data |
| intEnable | input | 1 | Global servicing enable pulse |
| intDisable | input | 1 | Global servicing disable pulse |
| irqAck | input | 1 | Sequencer accepts the presented request |
| irqDone | input | 1 | Sequencer ends the current service routine |
| irqReq | output | 1 | A request is presented |
| irqVec | output | 3 | Index of the presented source |

## Verification
Some properties are checked on every cycle:
- No request appears in the cycle after a mask write.
- A non-power-down vector always has its mask bit set.
- Nothing is presented during non-nested service.
- A disable pulse silences the next cycle.
- An accepted source is in service in the following cycle.

Other behaviour only the directed scenarios can show:
- The priority order between concurrent sources.
- Latching versus following for each sensitivity mode.
- The set-over-clear rule and the level sources that ignore set bits.
- Preemption under nesting, and the order in which sources retire.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int CFG_LINES = 3;
  localparam int LVL_LINES = 2;
  localparam int NSRC      = 1 + CFG_LINES + 1 + LVL_LINES;
  localparam int VEC_W     = $clog2(NSRC);
  localparam int DATA_W    = 2 * NSRC;
  localparam int CTRL_W    = CFG_LINES + 1;
  localparam int IDX_PWR   = 0;
  localparam int IDX_CFG0  = 1;
  localparam int IDX_EDGE  = IDX_CFG0 + CFG_LINES;
  localparam int IDX_LVL0  = IDX_EDGE + 1;
  localparam int NEST_BIT  = CFG_LINES;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_FRCLR = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            take;
    logic [NSRC-1:0] takeOh;
    logic [NSRC-1:0] retireOh;
  } ctlStrobe_t;

  // isolate lowest set bit (highest priority)
  function automatic logic [NSRC-1:0] lowOh(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction
endpackage

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intEnable,
  input  logic              intDisable,
  input  ctlStrobe_t        strobe,
  output logic [NSRC-1:0]   pending,
  output logic [NSRC-1:0]   maskQ,
  output logic              nestOn,
  output logic              globalEnQ,
  output logic [NSRC-1:0]   inSvcQ,
  output logic              maskWr
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [NSRC-1:0]   prevQ, latchQ, edgeMode, rise, setBits, clrBits;
  logic              frcWr;

  assign maskWr = wrEn && (wrSel == SEL_MASK);
  assign frcWr  = wrEn && (wrSel == SEL_FRCLR);
  assign nestOn = ctrlQ[NEST_BIT];

  // sensitivity per source
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_mode
      if (i == IDX_PWR || i == IDX_EDGE) begin : g_edge
        assign edgeMode[i] = 1'b1;
      end else if (i >= IDX_CFG0 && i < IDX_EDGE) begin : g_cfg
        assign edgeMode[i] = ctrlQ[i-IDX_CFG0];
      end else begin : g_lvl
        assign edgeMode[i] = 1'b0;
      end
    end
  endgenerate

  assign rise    = srcIn & ~prevQ;
  assign setBits = frcWr ? wrData[NSRC-1:0] : '0;
  assign clrBits = frcWr ? wrData[DATA_W-1:NSRC] : '0;
  assign pending = (latchQ & edgeMode) | (srcIn & ~edgeMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= '0;
      latchQ    <= '0;
      maskQ     <= '0;
      ctrlQ     <= '0;
      globalEnQ <= 1'b1;
      inSvcQ    <= '0;
    end else begin
      prevQ  <= srcIn;
      latchQ <= ((latchQ & ~strobe.takeOh & ~clrBits) | rise | setBits) & edgeMode;
      if (maskWr) maskQ <= wrData[NSRC-1:0];
      if (wrEn && wrSel == SEL_CTRL) ctrlQ <= wrData[CTRL_W-1:0];
      if (intDisable)     globalEnQ <= 1'b0;
      else if (intEnable) globalEnQ <= 1'b1;
      inSvcQ <= (inSvcQ & ~strobe.retireOh) | strobe.takeOh;
    end
  end

  p_svc_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> ((inSvcQ & $past(strobe.takeOh)) != '0));
  p_gdis_r7: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |=> !globalEnQ);
endmodule

// File: rtl/irq_ctl_control.sv
module irq_ctl_control
  import irq_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  pending,
  input  logic [NSRC-1:0]  maskQ,
  input  logic             nestOn,
  input  logic             globalEnQ,
  input  logic [NSRC-1:0]  inSvcQ,
  input  logic             maskWr,
  input  logic             irqAck,
  input  logic             irqDone,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVec,
  output ctlStrobe_t       strobe
);
  localparam logic [NSRC-1:0] PWR_OH = NSRC'(1) << IDX_PWR;

  logic            holdOffQ;
  logic [NSRC-1:0] enabled, allow, cand, pickOh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdOffQ <= 1'b0;
    else       holdOffQ <= maskWr;
  end

  assign enabled = pending & (maskQ | PWR_OH);

  // nesting ceiling: sources at or below any in-service level are barred
  always_comb begin
    logic busy;
    busy = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      busy     = busy | inSvcQ[i];
      allow[i] = nestOn ? !busy : (inSvcQ == '0);
    end
  end

  assign cand   = enabled & allow & {NSRC{globalEnQ && !holdOffQ}};
  assign pickOh = lowOh(cand);
  assign irqReq = |cand;

  always_comb begin
    irqVec = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (cand[i]) irqVec = VEC_W'(i);
  end

  assign strobe.take     = irqAck && irqReq;
  assign strobe.takeOh   = strobe.take ? pickOh : '0;
  assign strobe.retireOh = irqDone ? lowOh(inSvcQ) : '0;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> !irqReq);
  p_masked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqVec != VEC_W'(IDX_PWR)) |-> maskQ[irqVec]);
  p_nonest_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !nestOn) |-> (inSvcQ == '0));
  p_take_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.takeOh));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDownReq,
  input  logic [CFG_LINES-1:0] cfgLine,
  input  logic                 edgeLine,
  input  logic [LVL_LINES-1:0] lvlLine,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 intEnable,
  input  logic                 intDisable,
  input  logic                 irqAck,
  input  logic                 irqDone,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVec
);
  logic [NSRC-1:0] srcIn, pending, maskQ, inSvcQ;
  logic            nestOn, globalEnQ, maskWr;
  ctlStrobe_t      strobe;

  assign srcIn = {lvlLine, edgeLine, cfgLine, pwrDownReq};

  irq_ctl_datapath dp_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .intEnable(intEnable), .intDisable(intDisable),
    .strobe(strobe), .pending(pending), .maskQ(maskQ), .nestOn(nestOn),
    .globalEnQ(globalEnQ), .inSvcQ(inSvcQ), .maskWr(maskWr)
  );

  irq_ctl_control ctl_i (
    .clk(clk), .rstN(rstN), .pending(pending), .maskQ(maskQ),
    .nestOn(nestOn), .globalEnQ(globalEnQ), .inSvcQ(inSvcQ),
    .maskWr(maskWr), .irqAck(irqAck), .irqDone(irqDone),
    .irqReq(irqReq), .irqVec(irqVec), .strobe(strobe)
  );

  p_gdis_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |=> !irqReq);
endmodule

// File: tb/irq_ctl_top_tb_top.sv
module irq_ctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrDownReq = 1'b0;
  logic [2:0]  cfgLine = '0;
  logic        edgeLine = 1'b0;
  logic [1:0]  lvlLine = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [13:0] wrData = '0;
  logic        intEnable = 1'b0, intDisable = 1'b0;
  logic        irqAck = 1'b0, irqDone = 1'b0;
  logic        irqReq;
  logic [2:0]  irqVec;
  int checkCnt = 0, failCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_ctl_top dut_i (
    .clk(clk), .rstN(rstN), .pwrDownReq(pwrDownReq), .cfgLine(cfgLine),
    .edgeLine(edgeLine), .lvlLine(lvlLine), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .intEnable(intEnable), .intDisable(intDisable),
    .irqAck(irqAck), .irqDone(irqDone), .irqReq(irqReq), .irqVec(irqVec)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_req(string req, logic expReq, logic [2:0] expVec);
    checkCnt++;
    if (irqReq !== expReq || (expReq && irqVec !== expVec)) begin
      failCnt++;
      $display("FAIL %s: actual req=%0b vec=%0d expected req=%0b vec=%0d",
               req, irqReq, irqVec, expReq, expVec);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [13:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic ack();
    irqAck = 1'b1; step(); irqAck = 1'b0;
  endtask

  task automatic done();
    irqDone = 1'b1; step(); irqDone = 1'b0;
  endtask

  task automatic t_reset();
    expect_req("R10 reset", 1'b0, 3'd0);
    lvlLine[1] = 1'b1; step();
    expect_req("R10 mask zero after reset", 1'b0, 3'd0);
    lvlLine[1] = 1'b0; step();
  endtask

  task automatic t_power_down();
    pwrDownReq = 1'b1; step(); pwrDownReq = 1'b0;
    expect_req("R2 power-down with mask clear", 1'b1, 3'd0);
    ack();
    expect_req("R9 ack clears power-down latch", 1'b0, 3'd0);
    done();
    expect_req("R9 after done nothing pending", 1'b0, 3'd0);
  endtask

  task automatic t_mask_priority();
    lvlLine[1] = 1'b1; step();
    expect_req("R1 masked source not selected", 1'b0, 3'd0);
    wr(2'd0, 14'h007E);
    expect_req("R3 hold-off after mask write", 1'b0, 3'd0);
    step();
    expect_req("R3 request returns after one cycle", 1'b1, 3'd6);
    lvlLine[0] = 1'b1; step();
    expect_req("R1 index 5 beats 6", 1'b1, 3'd5);
    edgeLine = 1'b1; step();
    expect_req("R1 index 4 beats 5", 1'b1, 3'd4);
    edgeLine = 1'b0; lvlLine = '0; step();
    expect_req("R5 edge line stays latched, level lines drop", 1'b1, 3'd4);
    ack();
    expect_req("R9 ack edge line", 1'b0, 3'd0);
    done(); step();
    expect_req("R9 edge latch cleared by ack", 1'b0, 3'd0);
    lvlLine[1] = 1'b1; step();
    wr(2'd0, 14'h007E);
    expect_req("R3 hold-off with request present", 1'b0, 3'd0);
    step();
    expect_req("R3 request back", 1'b1, 3'd6);
    lvlLine[1] = 1'b0; step();
    expect_req("R5 level line not latched", 1'b0, 3'd0);
  endtask

  task automatic t_sensitivity();
    wr(2'd1, 14'h0001);
    cfgLine[0] = 1'b1; step(); cfgLine[0] = 1'b0;
    expect_req("R4 edge-mode line latched", 1'b1, 3'd1);
    step();
    expect_req("R4 edge-mode latch holds after fall", 1'b1, 3'd1);
    ack();
    expect_req("R8 no-nest blocks while in service", 1'b0, 3'd0);
    done();
    expect_req("R4 latch cleared by ack", 1'b0, 3'd0);
    cfgLine[1] = 1'b1; step();
    expect_req("R4 level-mode line follows input", 1'b1, 3'd2);
    cfgLine[1] = 1'b0; step();
    expect_req("R4 level-mode line drops", 1'b0, 3'd0);
  endtask

  task automatic t_force_clear();
    wr(2'd2, 14'h0010);
    expect_req("R6 set edge latch", 1'b1, 3'd4);
    wr(2'd2, 14'h0800);
    expect_req("R6 clear edge latch", 1'b0, 3'd0);
    wr(2'd2, 14'h0020);
    expect_req("R6 set bit on level source has no effect", 1'b0, 3'd0);
    wr(2'd3, 14'h0010);
    expect_req("R6 unused select ignored", 1'b0, 3'd0);
    wr(2'd2, 14'h0810);
    expect_req("R6 set wins over clear", 1'b1, 3'd4);
    wr(2'd2, 14'h0800);
    expect_req("R6 cleared again", 1'b0, 3'd0);
  endtask

  task automatic t_global();
    intDisable = 1'b1; step(); intDisable = 1'b0;
    pwrDownReq = 1'b1; step(); pwrDownReq = 1'b0;
    wr(2'd2, 14'h0010);
    expect_req("R7 disabled blocks power-down and others", 1'b0, 3'd0);
    intEnable = 1'b1; intDisable = 1'b1; step();
    intEnable = 1'b0; intDisable = 1'b0;
    expect_req("R7 disable wins over enable", 1'b0, 3'd0);
    intEnable = 1'b1; step(); intEnable = 1'b0;
    expect_req("R7 enable restores, power-down first", 1'b1, 3'd0);
    ack();
    expect_req("R8 no-nest hold during power-down service", 1'b0, 3'd0);
    done();
    expect_req("R7 latched source kept while disabled", 1'b1, 3'd4);
    ack(); done();
    expect_req("R9 all retired", 1'b0, 3'd0);
  endtask

  task automatic t_nesting();
    wr(2'd1, 14'h0009);
    wr(2'd2, 14'h0010);
    expect_req("R8 source 4 presented", 1'b1, 3'd4);
    ack();
    lvlLine[1] = 1'b1; step();
    expect_req("R8 lower priority barred while 4 in service", 1'b0, 3'd0);
    wr(2'd2, 14'h0002);
    expect_req("R8 higher priority preempts", 1'b1, 3'd1);
    ack();
    expect_req("R8 nested level 1 in service", 1'b0, 3'd0);
    done();
    expect_req("R9 done retires 1, 4 still in service", 1'b0, 3'd0);
    done();
    expect_req("R9 done retires 4", 1'b1, 3'd6);
    wr(2'd1, 14'h0000);
    expect_req("R8 nesting off, level still presented", 1'b1, 3'd6);
    ack();
    wr(2'd2, 14'h0010);
    expect_req("R8 no-nest blocks higher priority", 1'b0, 3'd0);
    done();
    expect_req("R8 sequential service after done", 1'b1, 3'd4);
    lvlLine[1] = 1'b0;
    ack(); done();
    expect_req("R9 final idle", 1'b0, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_power_down();
    t_mask_priority();
    t_sensitivity();
    t_force_clear();
    t_global();
    t_nesting();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule